// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is the integer register file of a processor built for code that makes many procedure calls. Software addresses 32 logical registers. Eight of them are globals and are shared by every procedure. The other 24 form a window of three groups of eight: incoming arguments (logical 8–15), private locals (16–23) and outgoing arguments (24–31). The physical storage is a ring of windows. The outgoing group of one window is the same storage as the incoming group of the window one call deeper, so a caller writes arguments and the callee reads them with no copy.

A current-window pointer picks the visible window. It moves one step deeper on a call and one step back on a return. A saved-window pointer marks the oldest window still held on chip. A call that would overrun the oldest resident window raises a one-cycle overflow trap instead of moving. A return into a window that is no longer resident raises a one-cycle underflow trap. The trap handler then uses the transfer port. It reads out the oldest window (spill) or writes back the window above it (fill), sixteen entries per window. It then retries the call or the return.

With the default parameters there are 136 physical registers: 8 globals and 8 windows of 16 unique registers each. Physical 0–7 are the globals. Window 0 holds its incoming group at physical 135 down to 128, its locals at 127 down to 120 and its outgoing group at 119 down to 112. Each deeper window sits 16 lower, and the deepest window's outgoing group wraps onto window 0's incoming group.

Top module: `winreg_file`

## Requirements
- R1: Logical registers 1–7 are global: a value written in one window reads back unchanged after any number of calls or returns.
- R2: A write to logical register 0 has no effect, and a read of logical 0 on either port returns zero, even when it coincides with a write to logical 0.
- R3: Logical 24+k in window w and logical 8+k in window w+1 (modulo the window count) are the same register, including the wrap from the last window to window 0.
- R4: Logical 16–23 are private to each window: a write in one window does not change them in a neighbouring window.
- R5: A call alone moves the current window one deeper and a return alone moves it one back. A call and a return in the same cycle are both ignored.
- R6: A call made while the current window is two steps short of the saved-window pointer (cwp+2 equals swp, modulo the window count) does not move the window. It pulses ovf_trap high for exactly the one cycle after the call.
- R7: A return made while the current window equals the saved-window pointer does not move the window. It pulses unf_trap high for exactly the one cycle after the return.
- R8: With xfer_en=1 and xfer_fill=0, xfer_rdata shows entry xfer_idx of the window at the saved-window pointer in the same cycle. Entries 0–7 are its logical 8–15 and entries 8–15 are its logical 16–23. The saved-window pointer advances by one after the cycle in which entry 15 is read.
- R9: With xfer_en=1 and xfer_fill=1, xfer_wdata is written to entry xfer_idx of the window one above the saved-window pointer, with the same entry layout as R8. The saved-window pointer retreats by one after entry 15 is written. A normal write in the same cycle is dropped.
- R10: A read of a register in the same cycle as a normal write to it returns the new data.
- R11: After reset every register reads zero, both trap outputs are low, and the current and saved window pointers are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_lreg | input | 5 | Read port 0 logical register |
| rd0_data | output | 32 | Read port 0 data (combinational) |
| rd1_lreg | input | 5 | Read port 1 logical register |
| rd1_data | output | 32 | Read port 1 data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_lreg | input | 5 | Write logical register |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Procedure call: move one window deeper |
| ret_i | input | 1 | Procedure return: move one window back |
| ovf_trap | output | 1 | Window overflow trap pulse |
| unf_trap | output | 1 | Window underflow trap pulse |
| xfer_en | input | 1 | Spill/fill transfer active |
| xfer_fill | input | 1 | 1 = fill (write), 0 = spill (read) |
| xfer_idx | input | 4 | Entry within the window being moved |
| xfer_wdata | input | 32 | Fill data |
| xfer_rdata | output | 32 | Spill data (combinational) |

## Verification
The assertions assume that the trap handler never asserts a call or a return while a transfer is active. They also assume it spills only when at least one older window is resident and fills only after an underflow. The pointer-motion checks hold only under that discipline. The bench keeps within it: every spill and fill it issues follows a trap it has just seen, and the call and return inputs stay low for the whole of each 16-entry transfer.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    localparam int unsigned WRF_DW    = 32;
    localparam int unsigned WRF_NWIN  = 8;
    localparam int unsigned WRF_GRP   = 8;
    localparam int unsigned WRF_NGLOB = 8;

    typedef enum logic {
        XFER_SPILL = 1'b0,
        XFER_FILL  = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
    parameter int unsigned NWIN  = wrf_pkg::WRF_NWIN,
    parameter int unsigned GRP   = wrf_pkg::WRF_GRP,
    parameter int unsigned NGLOB = wrf_pkg::WRF_NGLOB,
    localparam int unsigned LRW   = $clog2(NGLOB + 3 * GRP),
    localparam int unsigned WW    = $clog2(NWIN),
    localparam int unsigned NPHYS = NGLOB + NWIN * 2 * GRP,
    localparam int unsigned PW    = $clog2(NPHYS)
) (
    input  logic [LRW-1:0] lreg,
    input  logic [WW-1:0]  win,
    output logic [PW-1:0]  phys
);
    localparam int unsigned WINREGS = NWIN * 2 * GRP;
    localparam int unsigned OW      = $clog2(WINREGS);
    localparam int unsigned SH      = $clog2(2 * GRP);

    logic [OW-1:0] off;

    always_comb begin
        off = OW'({win, {SH{1'b0}}}) + OW'(lreg - LRW'(NGLOB));
        if (lreg < LRW'(NGLOB)) begin
            phys = PW'(lreg);
        end else begin
            phys = PW'(NPHYS - 1) - PW'(off);
        end
    end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
    parameter int unsigned NWIN = wrf_pkg::WRF_NWIN,
    parameter int unsigned GRP  = wrf_pkg::WRF_GRP,
    localparam int unsigned WW  = $clog2(NWIN),
    localparam int unsigned IW  = $clog2(2 * GRP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          xfer_en,
    input  logic          xfer_fill,
    input  logic [IW-1:0] xfer_idx,
    output logic [WW-1:0] cwp_o,
    output logic [WW-1:0] swp_o,
    output logic          ovf_o,
    output logic          unf_o
);
    import wrf_pkg::*;

    typedef struct packed {
        logic [WW-1:0] cwp;
        logic [WW-1:0] swp;
        logic          ovf;
        logic          unf;
    } st_t;

    st_t           s_d, s_q;
    logic [WW-1:0] used_m1;
    logic          full, empty, xfer_done;

    always_comb begin
        s_d       = s_q;
        s_d.ovf   = 1'b0;
        s_d.unf   = 1'b0;
        used_m1   = s_q.cwp - s_q.swp;
        full      = (used_m1 == WW'(NWIN - 2));
        empty     = (s_q.cwp == s_q.swp);
        xfer_done = xfer_en && (xfer_idx == IW'(2 * GRP - 1));
        if (call_i && !ret_i) begin
            if (full) s_d.ovf = 1'b1;
            else      s_d.cwp = s_q.cwp + 1'b1;
        end else if (ret_i && !call_i) begin
            if (empty) s_d.unf = 1'b1;
            else       s_d.cwp = s_q.cwp - 1'b1;
        end
        if (xfer_done) begin
            if (xfer_dir_e'(xfer_fill) == XFER_FILL) s_d.swp = s_q.swp - 1'b1;
            else                                     s_d.swp = s_q.swp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cwp_o = s_q.cwp;
    assign swp_o = s_q.swp;
    assign ovf_o = s_q.ovf;
    assign unf_o = s_q.unf;

    AST_OVF_HOLDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> cwp_o == $past(cwp_o)); // R6
    AST_UNF_HOLDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> cwp_o == $past(cwp_o)); // R7
    AST_UNF_FROM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> $past(ret_i) && !$past(call_i)); // R7
    AST_TRAPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o)); // R6
    AST_BOTH_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> $stable(cwp_o)); // R5
    AST_CALL_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !full) |=> cwp_o == WW'($past(cwp_o) + 1'b1)); // R5
    AST_SWP_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(swp_o) |-> $past(xfer_en)); // R8
    AST_NO_MOVE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |-> !(call_i || ret_i)); // R8
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
    parameter int unsigned DW    = wrf_pkg::WRF_DW,
    parameter int unsigned NPHYS = 136,
    parameter int unsigned NRD   = 3,
    localparam int unsigned PW   = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [PW-1:0] ra [NRD],
    output logic [DW-1:0] rd [NRD]
);
    logic [DW-1:0] rf_d [NPHYS];
    logic [DW-1:0] rf_q [NPHYS];
    logic          wr_ok;

    assign wr_ok = we && (wa != '0);

    always_comb begin
        rf_d = rf_q;
        if (wr_ok) rf_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd[g] = (wr_ok && (wa == ra[g])) ? wd : rf_q[ra[g]];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> rf_q[$past(wa)] == $past(wd)); // R10
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int unsigned DW    = wrf_pkg::WRF_DW,
    parameter int unsigned NWIN  = wrf_pkg::WRF_NWIN,
    parameter int unsigned GRP   = wrf_pkg::WRF_GRP,
    parameter int unsigned NGLOB = wrf_pkg::WRF_NGLOB,
    localparam int unsigned LRW  = $clog2(NGLOB + 3 * GRP),
    localparam int unsigned IW   = $clog2(2 * GRP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LRW-1:0] rd0_lreg,
    output logic [DW-1:0]  rd0_data,
    input  logic [LRW-1:0] rd1_lreg,
    output logic [DW-1:0]  rd1_data,
    input  logic           wr_en,
    input  logic [LRW-1:0] wr_lreg,
    input  logic [DW-1:0]  wr_data,
    input  logic           call_i,
    input  logic           ret_i,
    output logic           ovf_trap,
    output logic           unf_trap,
    input  logic           xfer_en,
    input  logic           xfer_fill,
    input  logic [IW-1:0]  xfer_idx,
    input  logic [DW-1:0]  xfer_wdata,
    output logic [DW-1:0]  xfer_rdata
);
    localparam int unsigned WW    = $clog2(NWIN);
    localparam int unsigned NPHYS = NGLOB + NWIN * 2 * GRP;
    localparam int unsigned PW    = $clog2(NPHYS);
    localparam int unsigned NMAP  = 4;
    localparam int unsigned NRD   = 3;

    logic [WW-1:0]  cwp, swp;
    logic [LRW-1:0] m_lreg [NMAP];
    logic [WW-1:0]  m_win  [NMAP];
    logic [PW-1:0]  m_phys [NMAP];
    logic [PW-1:0]  st_ra  [NRD];
    logic [DW-1:0]  st_rd  [NRD];
    logic           st_we, fill_wr;
    logic [PW-1:0]  st_wa;
    logic [DW-1:0]  st_wd;

    wrf_ctrl #(.NWIN(NWIN), .GRP(GRP)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .xfer_en(xfer_en), .xfer_fill(xfer_fill), .xfer_idx(xfer_idx),
        .cwp_o(cwp), .swp_o(swp), .ovf_o(ovf_trap), .unf_o(unf_trap)
    );

    always_comb begin
        m_lreg[0] = rd0_lreg;
        m_lreg[1] = rd1_lreg;
        m_lreg[2] = wr_lreg;
        m_lreg[3] = LRW'(NGLOB) + LRW'(xfer_idx);
        m_win[0]  = cwp;
        m_win[1]  = cwp;
        m_win[2]  = cwp;
        m_win[3]  = xfer_fill ? WW'(swp - 1'b1) : swp;
    end

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        wrf_map #(.NWIN(NWIN), .GRP(GRP), .NGLOB(NGLOB)) map_i (
            .lreg(m_lreg[g]), .win(m_win[g]), .phys(m_phys[g])
        );
    end

    always_comb begin
        fill_wr  = xfer_en && xfer_fill;
        st_we    = fill_wr || wr_en;
        st_wa    = fill_wr ? m_phys[3] : m_phys[2];
        st_wd    = fill_wr ? xfer_wdata : wr_data;
        st_ra[0] = m_phys[0];
        st_ra[1] = m_phys[1];
        st_ra[2] = m_phys[3];
    end

    wrf_store #(.DW(DW), .NPHYS(NPHYS), .NRD(NRD)) store_i (
        .clk(clk), .rst_n(rst_n), .we(st_we), .wa(st_wa), .wd(st_wd),
        .ra(st_ra), .rd(st_rd)
    );

    assign rd0_data   = st_rd[0];
    assign rd1_data   = st_rd[1];
    assign xfer_rdata = st_rd[2];

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_lreg == '0) |-> (rd0_data == '0)); // R2
    AST_BYPASS_NEW_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !xfer_en && wr_lreg != '0 && wr_lreg == rd1_lreg) |-> (rd1_data == wr_data)); // R10
endmodule

// File: tb/winreg_file_tb_top.sv
`timescale 1ns/1ps
module winreg_file_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd0_lreg, rd1_lreg, wr_lreg;
    logic [31:0] rd0_data, rd1_data, wr_data, xfer_wdata, xfer_rdata;
    logic        wr_en, call_i, ret_i, ovf_trap, unf_trap, xfer_en, xfer_fill;
    logic [3:0]  xfer_idx;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    winreg_file dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd0_lreg(rd0_lreg), .rd0_data(rd0_data),
        .rd1_lreg(rd1_lreg), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_lreg(wr_lreg), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap),
        .xfer_en(xfer_en), .xfer_fill(xfer_fill), .xfer_idx(xfer_idx),
        .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] r, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_lreg = r; wr_data = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] r, input logic [31:0] exp);
        @(negedge clk); rd0_lreg = r; rd1_lreg = r; #1;
        chk(req, rd0_data, exp);
        chk(req, rd1_data, exp);
    endtask

    task automatic move(input bit c, input bit r, input bit exp_o, input bit exp_u, input string req);
        @(negedge clk); call_i = c; ret_i = r;
        @(posedge clk); #1; call_i = 1'b0; ret_i = 1'b0;
        chk(req, 32'(ovf_trap), 32'(exp_o));
        chk(req, 32'(unf_trap), 32'(exp_u));
    endtask

    task automatic t_reset();
        rd("R11", 5'd1, 32'h0);
        rd("R11", 5'd17, 32'h0);
        chk("R11", 32'(ovf_trap), 32'h0);
        chk("R11", 32'(unf_trap), 32'h0);
    endtask

    task automatic t_zero();
        wr(5'd0, 32'hDEAD);
        rd("R2", 5'd0, 32'h0);
        @(negedge clk); wr_en = 1'b1; wr_lreg = 5'd0; wr_data = 32'hBEEF; rd0_lreg = 5'd0; #1;
        chk("R2", rd0_data, 32'h0);
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic t_bypass();
        @(negedge clk); wr_en = 1'b1; wr_lreg = 5'd9; wr_data = 32'h1111; rd0_lreg = 5'd9; #1;
        chk("R10", rd0_data, 32'h1111);
        @(posedge clk); #1; wr_en = 1'b0;
        rd("R10", 5'd9, 32'h1111);
        wr(5'd18, 32'h1818);
    endtask

    task automatic t_global();
        wr(5'd3, 32'h3333);
        move(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        rd("R1", 5'd3, 32'h3333);
        wr(5'd5, 32'h5555);
    endtask

    task automatic t_overlap();
        wr(5'd26, 32'hA26);
        wr(5'd17, 32'hB1);
        move(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        rd("R3", 5'd10, 32'hA26);
        rd("R4", 5'd17, 32'h0);
        wr(5'd17, 32'hB2);
        move(1'b0, 1'b1, 1'b0, 1'b0, "R5");
        rd("R4", 5'd17, 32'hB1);
        rd("R3", 5'd26, 32'hA26);
    endtask

    task automatic t_both();
        move(1'b1, 1'b1, 1'b0, 1'b0, "R5");
        rd("R5", 5'd17, 32'hB1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 5; i++) move(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        wr(5'd20, 32'h66);
        move(1'b1, 1'b0, 1'b1, 1'b0, "R6");
        @(posedge clk); #1;
        chk("R6", 32'(ovf_trap), 32'h0);
        rd("R6", 5'd20, 32'h66);
        rd("R1", 5'd5, 32'h5555);
    endtask

    task automatic t_spill();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); xfer_en = 1'b1; xfer_fill = 1'b0; xfer_idx = 4'(i); #1;
            chk("R8", xfer_rdata, (i == 1) ? 32'h1111 : (i == 10) ? 32'h1818 : 32'h0);
        end
        @(posedge clk); #1; xfer_en = 1'b0;
        move(1'b1, 1'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_wrap();
        wr(5'd24, 32'h7724);
        move(1'b1, 1'b0, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); xfer_en = 1'b1; xfer_fill = 1'b0; xfer_idx = 4'(i); #1;
            chk("R8", xfer_rdata, (i == 9) ? 32'hB1 : 32'h0);
        end
        @(posedge clk); #1; xfer_en = 1'b0;
        move(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        rd("R3", 5'd8, 32'h7724);
        rd("R3", 5'd9, 32'h1111);
    endtask

    task automatic t_underflow();
        for (int i = 0; i < 6; i++) move(1'b0, 1'b1, 1'b0, 1'b0, "R5");
        move(1'b0, 1'b1, 1'b0, 1'b1, "R7");
        @(posedge clk); #1;
        chk("R7", 32'(unf_trap), 32'h0);
        rd("R7", 5'd17, 32'hB2);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); xfer_en = 1'b1; xfer_fill = 1'b1; xfer_idx = 4'(i);
            xfer_wdata = 32'hF00 + 32'(i);
            wr_en = (i == 9); wr_lreg = 5'd19; wr_data = 32'hBAD;
        end
        @(posedge clk); #1; xfer_en = 1'b0; wr_en = 1'b0;
        rd("R9", 5'd19, 32'h0);
        move(1'b0, 1'b1, 1'b0, 1'b0, "R9");
        rd("R9", 5'd8, 32'hF00);
        rd("R9", 5'd17, 32'hF09);
        rd("R9", 5'd23, 32'hF0F);
    endtask

    initial begin
        #1_000_000;
        chk("watchdog", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_lreg = '0; wr_data = '0;
        rd0_lreg = '0; rd1_lreg = '0; call_i = 1'b0; ret_i = 1'b0;
        xfer_en = 1'b0; xfer_fill = 1'b0; xfer_idx = '0; xfer_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_zero();
        t_bypass();
        t_global();
        t_overlap();
        t_both();
        t_overflow();
        t_spill();
        t_wrap();
        t_underflow();
        t_fill();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule